// File: doc/BRIEF.md
# SPI Clock-Chip Time Sequencer

This block moves calendar time between a host and a serial real-time-clock chip. The host works in plain binary: seconds, minutes, hours 0-23, a 0-based weekday, day of month, month and a four-digit year. The chip stores packed BCD in a run of seven registers and may hold its hours in either a 12-hour or a 24-hour layout. The block produces the byte stream for each operation and hands it, one byte at a time, to a separate byte-level SPI engine. It also drives the chip enable that frames each transaction.

A get request opens one frame. The frame sends the start address of the time registers and then clocks in seven bytes, which the block masks, decodes and presents on its read outputs. These outputs hold their values until the next get request. A set request encodes the host fields and runs three frames. The first frame unlocks the chip's control register. The second frame writes the seven time bytes in one burst. The third frame locks the control register again.

Frames are separated by a chip-enable-low interval whose minimum length is set by a parameter. The host sees `busy` for the length of a sequence and a one-cycle `done` when the sequence ends.

Top module: `rtc_time_seq`

## Requirements
- R1: After reset `busy`, `done`, `spi_cs` and `spi_start` are low. The read outputs show 00:00:00, weekday 0, day 1, month 1, year 2000.
- R2: A get request makes exactly one chip-enable frame of eight bytes. The first byte is 0x00, a read address with bit 7 clear. The seven bytes that follow are taken as seconds, minutes, hours, weekday, day of month, month and year, in that order.
- R3: Read decoding masks the fields before BCD conversion: seconds and minutes to 7 bits, day of month to 6 bits, month to 5 bits and weekday to 3 bits. Each field decodes as high nibble times ten plus low nibble. The year output is the decoded value plus 2000. The weekday output is the stored value minus one.
- R4: When bit 6 of the hours byte is set, bit 5 is the PM flag and bits 4:0 hold the BCD hour 1-12. The decode maps 12 AM to 0 and 12 PM to 12, adds 12 to the other PM hours, and passes the other AM hours through unchanged.
- R5: When bit 6 of the hours byte is clear, bits 5:0 hold the BCD hour 0-23.
- R6: A set request makes three frames in order:
  - {0x8F, 0x00}, which clears write protect in the control register at address 0x0F;
  - {0x80, seven time bytes}, a burst write starting at address 0x00;
  - {0x8F, 0x40}, which restores write protect.
- R7: Set encoding puts the tens digit in the high nibble and the units digit in the low nibble. The hours are written in 24-hour form with bit 6 clear. The stored weekday is the host weekday plus one. The stored year is the host year minus 2000.
- R8: `busy` rises in the cycle after an accepted request and stays high until `done`. `done` is high for one cycle, with chip enable low. Get or set requests that arrive while `busy` is high are ignored.
- R9: Chip enable stays low for at least `CE_GAP` clock cycles between any two frames.
- R10: `spi_start` is only asserted while chip enable is high. At most one byte is outstanding with the engine at a time. Chip enable falls only after the last byte of the frame has completed.
- R11: If get and set are requested in the same cycle, the get is performed and the set is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| get_req | input | 1 | Start a time read |
| set_req | input | 1 | Start a time write |
| set_sec | input | 6 | Seconds to write, 0-59 |
| set_min | input | 6 | Minutes to write, 0-59 |
| set_hour | input | 5 | Hours to write, 0-23 |
| set_wday | input | 3 | Weekday to write, 0-6 |
| set_mday | input | 5 | Day of month to write, 1-31 |
| set_mon | input | 4 | Month to write, 1-12 |
| set_year | input | 12 | Year to write, 2000-2099 |
| get_sec | output | 6 | Seconds read |
| get_min | output | 6 | Minutes read |
| get_hour | output | 5 | Hours read, 0-23 |
| get_wday | output | 3 | Weekday read, 0-based |
| get_mday | output | 5 | Day of month read |
| get_mon | output | 4 | Month read |
| get_year | output | 12 | Year read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| spi_cs | output | 1 | Chip enable to the clock chip, active high |
| spi_start | output | 1 | Byte-transfer request to the SPI engine |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Engine has finished the current byte |
| spi_rx | input | 8 | Byte shifted in |

## Verification
The bench builds the block with `CE_GAP` = 3 instead of the default 4. Its SPI engine model answers each byte two cycles after the start. Three gap cycles keep every set sequence short, yet the bench can still tell a correct gap apart from one that is a cycle short. The short engine latency makes back-to-back bytes and a request pulsed during a busy sequence happen within a few dozen cycles.

// File: rtl/rtc_time_seq.sv
module rtc_time_seq #(
  parameter int CE_GAP    = 4,
  parameter int YEAR_BASE = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        get_req,
  input  logic        set_req,
  input  logic [5:0]  set_sec,
  input  logic [5:0]  set_min,
  input  logic [4:0]  set_hour,
  input  logic [2:0]  set_wday,
  input  logic [4:0]  set_mday,
  input  logic [3:0]  set_mon,
  input  logic [11:0] set_year,
  output logic [5:0]  get_sec,
  output logic [5:0]  get_min,
  output logic [4:0]  get_hour,
  output logic [2:0]  get_wday,
  output logic [4:0]  get_mday,
  output logic [3:0]  get_mon,
  output logic [11:0] get_year,
  output logic        busy,
  output logic        done,
  output logic        spi_cs,
  output logic        spi_start,
  output logic [7:0]  spi_tx,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx
);
  localparam int GW = $clog2(CE_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_GAP, S_DONE} st_t;

  st_t          st;
  logic         op_rd;
  logic [1:0]   txn;
  logic [2:0]   idx;
  logic [GW-1:0] gcnt;
  logic [7:0]   raw [8];
  logic [7:0]   enc [8];

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] n);
    logic [6:0] t, u;
    t = n / 7'd10;
    u = n % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  wire [2:0] last_idx = (op_rd || txn == 2'd1) ? 3'd7 : 3'd1;
  wire [1:0] last_txn = op_rd ? 2'd0 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_rd  <= 1'b0;
      txn    <= '0;
      idx    <= '0;
      gcnt   <= '0;
      spi_cs <= 1'b0;
      for (int i = 0; i < 8; i++) begin
        raw[i] <= (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
        enc[i] <= 8'h00;
      end
    end else begin
      case (st)
        S_IDLE: if (get_req || set_req) begin
          op_rd  <= get_req;
          txn    <= '0;
          idx    <= '0;
          spi_cs <= 1'b1;
          st     <= S_LOAD;
          if (!get_req) begin
            enc[0] <= bin2bcd(7'(set_sec));
            enc[1] <= bin2bcd(7'(set_min));
            enc[2] <= bin2bcd(7'(set_hour));
            enc[3] <= bin2bcd(7'(set_wday) + 7'd1);
            enc[4] <= bin2bcd(7'(set_mday));
            enc[5] <= bin2bcd(7'(set_mon));
            enc[6] <= bin2bcd(7'(set_year - 12'(YEAR_BASE)));
          end
        end
        S_LOAD: st <= S_WAIT;
        S_WAIT: if (spi_done) begin
          if (op_rd && idx != 3'd0) raw[idx - 3'd1] <= spi_rx;
          if (idx == last_idx) begin
            spi_cs <= 1'b0;
            gcnt   <= '0;
            st     <= S_GAP;
          end else begin
            idx <= idx + 3'd1;
            st  <= S_LOAD;
          end
        end
        S_GAP: if (gcnt == GW'(CE_GAP - 1)) begin
          if (txn == last_txn) st <= S_DONE;
          else begin
            txn    <= txn + 2'd1;
            idx    <= '0;
            spi_cs <= 1'b1;
            st     <= S_LOAD;
          end
        end else gcnt <= gcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (op_rd) spi_tx = 8'h00;
    else if (txn == 2'd1) spi_tx = (idx == 3'd0) ? 8'h80 : enc[idx - 3'd1];
    else if (idx == 3'd0) spi_tx = 8'h8F;
    else spi_tx = (txn == 2'd0) ? 8'h00 : 8'h40;
  end

  assign spi_start = (st == S_LOAD);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);

  logic [7:0] h12, h24, hsel;
  assign h12 = bcd2bin({3'b0, raw[2][4:0]});
  assign h24 = bcd2bin({2'b0, raw[2][5:0]});
  always_comb begin
    if (!raw[2][6])     hsel = h24;
    else if (h12 == 8'd12) hsel = raw[2][5] ? 8'd12 : 8'd0;
    else                hsel = raw[2][5] ? h12 + 8'd12 : h12;
  end

  assign get_sec  = 6'(bcd2bin({1'b0, raw[0][6:0]}));
  assign get_min  = 6'(bcd2bin({1'b0, raw[1][6:0]}));
  assign get_hour = hsel[4:0];
  assign get_wday = raw[3][2:0] - 3'd1;
  assign get_mday = 5'(bcd2bin({2'b0, raw[4][5:0]}));
  assign get_mon  = 4'(bcd2bin({3'b0, raw[5][4:0]}));
  assign get_year = 12'(YEAR_BASE) + {4'd0, bcd2bin(raw[6])};
endmodule

// File: rtl/rtc_time_seq_chk.sv
module rtc_time_seq_chk #(
  parameter int CE_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic spi_cs,
  input logic spi_start,
  input logic spi_done
);
  logic pend;
  logic seen;
  int   lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      seen   <= 1'b0;
      lowcnt <= 0;
    end else begin
      if (spi_start) pend <= 1'b1;
      else if (spi_done) pend <= 1'b0;
      if (spi_cs) begin
        seen   <= 1'b1;
        lowcnt <= 0;
      end else if (lowcnt < CE_GAP) lowcnt <= lowcnt + 1;
    end
  end

  a_r10_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> spi_cs);
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !pend);
  a_r10_cs_falls_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs) |-> !pend);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !spi_cs));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!spi_cs && !spi_start));
  a_r9_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs) |-> (!seen || lowcnt >= CE_GAP));
endmodule

bind rtc_time_seq rtc_time_seq_chk #(.CE_GAP(CE_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .spi_cs(spi_cs), .spi_start(spi_start), .spi_done(spi_done)
);

// File: tb/tb_rtc_time_seq.sv
module tb_rtc_time_seq;
  localparam int GAP = 3;
  localparam int LAT = 2;

  logic clk = 0, rst_n = 0;
  logic get_req = 0, set_req = 0;
  logic [5:0] set_sec = 0, set_min = 0;
  logic [4:0] set_hour = 0, set_mday = 0;
  logic [2:0] set_wday = 0;
  logic [3:0] set_mon = 0;
  logic [11:0] set_year = 12'd2000;
  logic [5:0] get_sec, get_min;
  logic [4:0] get_hour, get_mday;
  logic [2:0] get_wday;
  logic [3:0] get_mon;
  logic [11:0] get_year;
  logic busy, done, spi_cs, spi_start;
  logic [7:0] spi_tx;
  logic spi_done = 0;
  logic [7:0] spi_rx = 0;

  logic bd_we = 0;
  logic [6:0] bd_a = 0;
  logic [7:0] bd_d = 0;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rtc_time_seq #(.CE_GAP(GAP)) dut (.*);

  logic [7:0] mem [0:127];
  logic [7:0] ctrl;
  int nfr, cnt, proto_err, dcnt, lowrun, gap_min;
  logic [7:0] fa [0:63];
  logic [7:0] fsec [0:63];
  int fl [0:63];
  logic first, wr, cs_d;
  logic [6:0] addr;
  logic [7:0] rxh;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    ctrl = 8'h40; nfr = 0; cnt = 0; proto_err = 0; dcnt = 0;
    lowrun = 0; gap_min = 1000; first = 0; wr = 0; cs_d = 0; addr = 0; rxh = 0;
  end

  always @(posedge clk) begin
    spi_done <= 1'b0;
    if (bd_we) mem[bd_a] = bd_d;
    if (done) dcnt = dcnt + 1;
    if (spi_cs && !cs_d) begin
      if (nfr > 0 && lowrun < gap_min) gap_min = lowrun;
      fl[nfr] = 0; nfr = nfr + 1; first = 1;
    end
    if (!spi_cs) lowrun = lowrun + 1; else lowrun = 0;
    cs_d = spi_cs;
    if (spi_start) begin
      if (!spi_cs || cnt > 0) proto_err = proto_err + 1;
      rxh = 8'h00;
      if (first) begin
        addr = spi_tx[6:0]; wr = spi_tx[7]; first = 0; fa[nfr-1] = spi_tx;
      end else begin
        if (fl[nfr-1] == 1) fsec[nfr-1] = spi_tx;
        if (wr) begin
          if (addr == 7'h0F) ctrl = spi_tx;
          else if (!ctrl[6]) mem[addr] = spi_tx;
        end else rxh = mem[addr];
        addr = addr + 7'd1;
      end
      fl[nfr-1] = fl[nfr-1] + 1;
      cnt = LAT;
    end else if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin spi_done <= 1'b1; spi_rx <= rxh; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk); bd_we = 1; bd_a = 7'(a); bd_d = d;
    @(negedge clk); bd_we = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic do_get();
    @(negedge clk); get_req = 1;
    @(negedge clk); get_req = 0;
    wait_done();
  endtask

  task automatic preload(input logic [7:0] b0, b1, b2, b3, b4, b5, b6);
    poke(0, b0); poke(1, b1); poke(2, b2); poke(3, b3);
    poke(4, b4); poke(5, b5); poke(6, b6);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 cs", spi_cs, 0);
    chk("R1 start", spi_start, 0);
    chk("R1 sec", get_sec, 0); chk("R1 hour", get_hour, 0); chk("R1 wday", get_wday, 0);
    chk("R1 mday", get_mday, 1); chk("R1 mon", get_mon, 1); chk("R1 year", get_year, 2000);
  endtask

  task automatic t_read24();
    int b;
    preload(8'h45, 8'h30, 8'h23, 8'h03, 8'h15, 8'h08, 8'h24);
    b = nfr;
    @(negedge clk); get_req = 1;
    @(negedge clk); get_req = 0;
    chk("R8 busy after request", busy, 1);
    wait_done();
    chk("R2 one frame", nfr - b, 1); chk("R2 addr byte", fa[b], 8'h00); chk("R2 length", fl[b], 8);
    chk("R3 sec", get_sec, 45); chk("R3 min", get_min, 30); chk("R5 hour 23", get_hour, 23);
    chk("R3 wday", get_wday, 2); chk("R3 mday", get_mday, 15); chk("R3 mon", get_mon, 8);
    chk("R3 year", get_year, 2024); chk("R8 idle after done", busy, 0);
  endtask

  task automatic t_masks();
    preload(8'hD9, 8'hB7, 8'h80, 8'hFF, 8'hF1, 8'hF2, 8'h99);
    do_get();
    chk("R3 sec mask", get_sec, 59); chk("R3 min mask", get_min, 37);
    chk("R5 hour 0 bit7 ignored", get_hour, 0); chk("R3 wday mask", get_wday, 6);
    chk("R3 mday mask", get_mday, 31); chk("R3 mon mask", get_mon, 12);
    chk("R3 year 99", get_year, 2099);
  endtask

  task automatic t_hour12();
    logic [7:0] hb [5] = '{8'h52, 8'h72, 8'h61, 8'h49, 8'h71};
    int ex [5] = '{0, 12, 13, 9, 23};
    for (int i = 0; i < 5; i++) begin
      poke(2, hb[i]);
      do_get();
      chk("R4 twelve-hour decode", get_hour, ex[i]);
    end
  endtask

  task automatic t_set();
    int b;
    b = nfr;
    @(negedge clk);
    set_sec = 59; set_min = 7; set_hour = 18; set_wday = 6;
    set_mday = 29; set_mon = 2; set_year = 12'd2038; set_req = 1;
    @(negedge clk); set_req = 0;
    wait_done();
    chk("R6 frames", nfr - b, 3);
    chk("R6 f0 addr", fa[b], 8'h8F); chk("R6 f0 data", fsec[b], 8'h00); chk("R6 f0 len", fl[b], 2);
    chk("R6 f1 addr", fa[b+1], 8'h80); chk("R6 f1 len", fl[b+1], 8);
    chk("R6 f2 addr", fa[b+2], 8'h8F); chk("R6 f2 data", fsec[b+2], 8'h40); chk("R6 f2 len", fl[b+2], 2);
    chk("R6 protect restored", ctrl, 8'h40);
    chk("R7 sec", mem[0], 8'h59); chk("R7 min", mem[1], 8'h07); chk("R7 hour", mem[2], 8'h18);
    chk("R7 wday+1", mem[3], 8'h07); chk("R7 mday", mem[4], 8'h29); chk("R7 mon", mem[5], 8'h02);
    chk("R7 year-2000", mem[6], 8'h38);
    do_get();
    chk("R7 round trip hour", get_hour, 18); chk("R7 round trip wday", get_wday, 6);
    chk("R7 round trip year", get_year, 2038);
    chk("R9 min gap", (gap_min >= GAP) ? 1 : 0, 1);
  endtask

  task automatic t_busy_ignore();
    int b, d;
    b = nfr; d = dcnt;
    @(negedge clk); get_req = 1;
    @(negedge clk); get_req = 0;
    repeat (4) @(negedge clk);
    set_sec = 1; set_req = 1;
    @(negedge clk); set_req = 0; get_req = 1;
    @(negedge clk); get_req = 0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R8 ignored frames", nfr - b, 1); chk("R8 one done", dcnt - d, 1);
    chk("R8 mem untouched", mem[0], 8'h59); chk("R8 busy low", busy, 0);
  endtask

  task automatic t_both();
    int b;
    b = nfr;
    @(negedge clk); set_sec = 3; get_req = 1; set_req = 1;
    @(negedge clk); get_req = 0; set_req = 0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R11 one frame", nfr - b, 1); chk("R11 read addr", fa[b], 8'h00);
    chk("R11 mem untouched", mem[0], 8'h59);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read24();
    t_masks();
    t_hour12();
    t_set();
    t_busy_ignore();
    t_both();
    chk("R10 engine protocol", proto_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule